// File: doc/BRIEF.md
# Key-Protected System Configuration Register Bank

This block is a small bank of system-control registers that sits on a simple single-cycle register bus. Two of its registers are protected. They are the device-configuration word, which holds the port-mux bits, the feature-enable bits and a software-reset bit, and the clock-divider word. Software can change a protected register only with a write that comes straight after a write of the key value 0xAA to the lock register. The usual sequence is to read the register, modify the value, write the key, and then write the new value.

A third register is read-only. It carries the chip revision in a bit field that software masks out and shifts down. The configuration and divider words are also driven out continuously on ports so that the surrounding muxes and dividers can use them.

Software starts a system reset by setting the reset bit in the configuration word and then clearing it. The clearing write produces a one-cycle, registered reset request.

Top module: `syscfg_lockbank`

## Requirements
- R1: After reset, the configuration word holds ones in its MUX_W lowest bits, so every shared port defaults to general-purpose I/O, and zeros in all other bits. The divider word holds CLKDIV_INIT. The lock register reads 0 and `sw_reset_req` is low.
- R2: A write of exactly 0xAA to word address 0 (the lock register) arms the unlock. While the unlock is armed, bit 0 of the lock register reads 1.
- R3: A write to address 1 (configuration) or address 2 (divider) that is the very next bus access after the arming write takes effect at the following clock edge. That write consumes the unlock, so bit 0 of the lock register reads 0 afterwards.
- R4: Any other bus access made while the unlock is armed cancels the unlock. This covers a read of any address, a write to address 3 or to an unmapped address, and a write of any value other than 0xAA to address 0. A further write of 0xAA keeps the unlock armed.
- R5: A write to address 1 or 2 made while the unlock is not armed leaves the register unchanged and sets bit 1 of the lock register. That bit stays set until reset.
- R6: Address 3 reads CHIP_REV in bits [REV_LSB +: REV_W] and zero in all other bits. Writes to address 3 change nothing.
- R7: When bit RST_BIT of the configuration word changes from 1 to 0, `sw_reset_req` goes high for exactly one cycle. The pulse starts at the first clock edge after the edge that stored the cleared bit. A change from 0 to 1 produces no pulse.
- R8: `cfg_out` and `clkdiv_out` always equal the words that read back at addresses 1 and 2.
- R9: Word addresses 4 and above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A bus access is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `req_addr` |
| cfg_out | output | DATA_W | Current configuration word |
| clkdiv_out | output | DATA_W | Current clock-divider word |
| sw_reset_req | output | 1 | Registered one-cycle software-reset request |

## Verification
The bench builds the block with a 16-bit word, MUX_W = 4, the reset bit at bit 15, the revision field at bits [11:8] with value 9, and a nonzero divider reset value of 3. This narrow word keeps the expected words easy to read. It places the reset bit at the top bit of the word, and it makes the unmapped addresses 4 to 7 reachable within the 3-bit address. A nonzero divider reset value lets the bench tell an ignored write apart from a cleared register.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

  localparam logic [7:0] UNLOCK_KEY = 8'hAA;

  typedef enum logic [1:0] {
    SEL_LOCK   = 2'd0,
    SEL_DEVCFG = 2'd1,
    SEL_CLKDIV = 2'd2,
    SEL_SYSID  = 2'd3
  } regsel_e;

  typedef struct packed {
    logic    hit;
    regsel_e sel;
  } decode_t;

  // Word addresses 0..3 are mapped; anything higher misses.
  function automatic decode_t decode_addr(input logic [7:0] a);
    decode_t d;
    d.hit = (a[7:2] == 6'd0);
    d.sel = regsel_e'(a[1:0]);
    return d;
  endfunction

endpackage

// File: rtl/syscfg_unlock.sv
module syscfg_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic acc_write,
  input  logic sel_lock,
  input  logic sel_prot,
  input  logic key_match,
  output logic armed,
  output logic accept,
  output logic violation,
  output logic err
);
  logic armed_q, err_q;
  logic arm_now;

  assign arm_now   = acc_valid & acc_write & sel_lock & key_match;
  assign accept    = acc_valid & acc_write & sel_prot & armed_q;
  assign violation = acc_valid & acc_write & sel_prot & ~armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (acc_valid) armed_q <= arm_now;
      if (violation) err_q   <= 1'b1;
    end
  end

  assign armed = armed_q;
  assign err   = err_q;
endmodule

// File: rtl/syscfg_fall_pulse.sv
module syscfg_fall_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic level_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      level_q <= level;
      pulse_q <= level_q & ~level;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/syscfg_lockbank.sv
module syscfg_lockbank #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int MUX_W       = 8,
  parameter int RST_BIT     = 31,
  parameter int REV_LSB     = 28,
  parameter int REV_W       = 4,
  parameter int CHIP_REV    = 5,
  parameter int CLKDIV_INIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] cfg_out,
  output logic [DATA_W-1:0] clkdiv_out,
  output logic              sw_reset_req
);
  import syscfg_pkg::*;

  localparam logic [DATA_W-1:0] DEVCFG_INIT = DATA_W'({MUX_W{1'b1}});
  localparam logic [DATA_W-1:0] CLKDIV_RST  = DATA_W'(CLKDIV_INIT);

  function automatic logic [DATA_W-1:0] sysid_word();
    logic [REV_W-1:0] r;
    r = REV_W'(CHIP_REV);
    return DATA_W'(r) << REV_LSB;
  endfunction

  decode_t dec;
  logic    sel_lock, sel_prot, key_match;
  logic    unlock_armed, unlock_accept, unlock_violation, unlock_err;
  logic    dev_wr, div_wr;
  logic [DATA_W-1:0] devcfg_q, clkdiv_q;

  assign dec       = decode_addr(8'(req_addr));
  assign sel_lock  = dec.hit && dec.sel == SEL_LOCK;
  assign sel_prot  = dec.hit && (dec.sel == SEL_DEVCFG || dec.sel == SEL_CLKDIV);
  assign key_match = (req_wdata == DATA_W'(UNLOCK_KEY));

  syscfg_unlock u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (req_valid),
    .acc_write (req_write),
    .sel_lock  (sel_lock),
    .sel_prot  (sel_prot),
    .key_match (key_match),
    .armed     (unlock_armed),
    .accept    (unlock_accept),
    .violation (unlock_violation),
    .err       (unlock_err)
  );

  assign dev_wr = unlock_accept && dec.sel == SEL_DEVCFG;
  assign div_wr = unlock_accept && dec.sel == SEL_CLKDIV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devcfg_q <= DEVCFG_INIT;
      clkdiv_q <= CLKDIV_RST;
    end else begin
      if (dev_wr) devcfg_q <= req_wdata;
      if (div_wr) clkdiv_q <= req_wdata;
    end
  end

  syscfg_fall_pulse u_rstpulse (
    .clk   (clk),
    .rst_n (rst_n),
    .level (devcfg_q[RST_BIT]),
    .pulse (sw_reset_req)
  );

  always_comb begin
    rd_data = '0;
    if (dec.hit) begin
      unique case (dec.sel)
        SEL_LOCK:   rd_data = DATA_W'({unlock_err, unlock_armed});
        SEL_DEVCFG: rd_data = devcfg_q;
        SEL_CLKDIV: rd_data = clkdiv_q;
        SEL_SYSID:  rd_data = sysid_word();
        default:    rd_data = '0;
      endcase
    end
  end

  assign cfg_out    = devcfg_q;
  assign clkdiv_out = clkdiv_q;
endmodule

// File: rtl/syscfg_lockbank_chk.sv
module syscfg_lockbank_chk #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32,
  parameter int REV_LSB  = 28,
  parameter int REV_W    = 4,
  parameter int CHIP_REV = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] cfg_out,
  input logic              sw_reset_req,
  input logic              armed,
  input logic              accept,
  input logic              violation,
  input logic              err,
  input logic              dev_wr
);
  // R2
  key_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(0) &&
     req_wdata == DATA_W'(syscfg_pkg::UNLOCK_KEY)) |=> armed);

  // R4
  read_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !armed);

  // R3
  accept_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !armed);

  // R5
  violation_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> err);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_req |=> !sw_reset_req);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_wr |=> $stable(cfg_out));

  // R6
  rev_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == ADDR_W'(3)) |-> rd_data[REV_LSB +: REV_W] == REV_W'(CHIP_REV));
endmodule

bind syscfg_lockbank syscfg_lockbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REV_LSB(REV_LSB),
  .REV_W(REV_W), .CHIP_REV(CHIP_REV)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_wdata    (req_wdata),
  .rd_data      (rd_data),
  .cfg_out      (cfg_out),
  .sw_reset_req (sw_reset_req),
  .armed        (unlock_armed),
  .accept       (unlock_accept),
  .violation    (unlock_violation),
  .err          (unlock_err),
  .dev_wr       (dev_wr)
);

// File: tb/sim_syscfg_lockbank.sv
`timescale 1ns/1ps
module sim_syscfg_lockbank;
  localparam int AW = 3, DW = 16, MW = 4, RB = 15, RL = 8, RW = 4, REV = 9, CDI = 3;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          v = 1'b0, w = 1'b0;
  logic [AW-1:0] a = '0;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] rd_data, cfg_out, clkdiv_out;
  logic          sw_reset_req;

  int total = 0, failed = 0;
  bit done = 0;

  // Behavioural reference state
  int m_dev, m_div;
  bit m_armed, m_err, m_prev_rst, m_pulse;

  always #2 clk = ~clk;

  syscfg_lockbank #(.ADDR_W(AW), .DATA_W(DW), .MUX_W(MW), .RST_BIT(RB),
    .REV_LSB(RL), .REV_W(RW), .CHIP_REV(REV), .CLKDIV_INIT(CDI)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(v), .req_write(w), .req_addr(a),
    .req_wdata(d), .rd_data(rd_data), .cfg_out(cfg_out),
    .clkdiv_out(clkdiv_out), .sw_reset_req(sw_reset_req));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int m_read(input int addr);
    case (addr)
      0: return (m_err ? 2 : 0) + (m_armed ? 1 : 0);
      1: return m_dev;
      2: return m_div;
      3: return REV * 256;
      default: return 0;
    endcase
  endfunction

  // One bus cycle: drive, check read data, clock the model, check outputs.
  task automatic step(input string tag, input bit vv, input bit ww,
                      input int aa, input int dd);
    bit np;
    v = vv; w = ww; a = AW'(aa); d = DW'(dd);
    #1;
    check(tag, int'(rd_data), m_read(aa));
    @(posedge clk);
    np = m_prev_rst && (((m_dev >> RB) & 1) == 0);
    m_prev_rst = ((m_dev >> RB) & 1) != 0;
    m_pulse = np;
    if (vv) begin
      if (ww && (aa == 1 || aa == 2)) begin
        if (m_armed) begin
          if (aa == 1) m_dev = dd; else m_div = dd;
        end else m_err = 1;
      end
      m_armed = ww && aa == 0 && dd == 'hAA;
    end
    #1;
    check("R8 cfg_out", int'(cfg_out), m_dev);
    check("R8 clkdiv_out", int'(clkdiv_out), m_div);
    check("R7 sw_reset_req", int'(sw_reset_req), int'(m_pulse));
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog (all R): actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", total, failed);
      $finish;
    end
  end

  initial begin
    m_dev = 'h000F; m_div = CDI; m_armed = 0; m_err = 0; m_prev_rst = 0; m_pulse = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state through all mapped reads
    step("R1 lock", 1, 0, 0, 0);
    step("R1 devcfg", 1, 0, 1, 0);
    step("R1 clkdiv", 1, 0, 2, 0);
    step("R6 sysid", 1, 0, 3, 0);
    // R5 unprotected write ignored, flag sticks
    step("R5 bad write", 1, 1, 1, 'h1234);
    step("R5 lock flag", 1, 0, 0, 0);
    step("R5 devcfg kept", 1, 0, 1, 0);
    // R2/R3 key then write
    step("R2 key", 1, 1, 0, 'hAA);
    step("R2 lock armed", 0, 0, 0, 0);
    step("R3 devcfg write", 1, 1, 1, 'h00F0);
    step("R3 lock consumed", 1, 0, 0, 0);
    // R4 repeated key stays armed
    step("R4 key", 1, 1, 0, 'hAA);
    step("R4 key again", 1, 1, 0, 'hAA);
    step("R3 clkdiv write", 1, 1, 2, 'h0042);
    // R4 read cancels
    step("R4 key", 1, 1, 0, 'hAA);
    step("R4 read lock", 1, 0, 0, 0);
    step("R4 cancelled write", 1, 1, 2, 'h7777);
    // R9 unmapped write cancels and reads zero
    step("R9 key", 1, 1, 0, 'hAA);
    step("R9 unmapped write", 1, 1, 5, 'hFFFF);
    step("R9 cancelled write", 1, 1, 1, 'h5555);
    step("R9 unmapped read", 1, 0, 6, 0);
    // R4 wrong key value
    step("R4 key", 1, 1, 0, 'hAA);
    step("R4 wrong key", 1, 1, 0, 'h55);
    step("R4 cancelled write", 1, 1, 1, 'h5555);
    // R6 write to read-only word
    step("R6 key", 1, 1, 0, 'hAA);
    step("R6 sysid write", 1, 1, 3, 'hFFFF);
    step("R6 cancelled write", 1, 1, 1, 'h0101);
    step("R6 sysid read", 1, 0, 3, 0);
    // R7 set then clear the reset bit
    step("R7 key", 1, 1, 0, 'hAA);
    step("R7 set bit", 1, 1, 1, 'h80F0);
    idle("R7 idle");
    idle("R7 idle");
    step("R7 key", 1, 1, 0, 'hAA);
    step("R7 clear bit", 1, 1, 1, 'h00F0);
    for (int i = 0; i < 4; i++) idle("R7 pulse window");
    step("R8 devcfg read", 1, 0, 1, 0);
    step("R8 clkdiv read", 1, 0, 2, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule